// File: doc/BRIEF.md
# Recursive Weighted Echo Filter

This block applies an echo to a stream of signed 16-bit audio samples. Each result mixes the incoming sample with the result the block produced D samples before it. The incoming sample has weight five and the stored result has weight four, and the sum is divided by nine. The stored term is filtered output, not raw input, so every echo is fed back again and fades away geometrically. A short D gives a dense, room-like tail. A long D gives separate, distinct repeats.

Samples enter and leave on valid/ready handshakes. When the consumer is always ready, the block takes one sample per clock. The history is kept in an on-chip circular buffer of up to 4096 entries, and its length is set through a configuration strobe. After reset, and after every configuration write, the history is treated as empty. The first D samples therefore come out unchanged, and mixing starts after them.

Top module: `recho_filter`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `in_ready` is 1 and the delay length is `DEFAULT_DELAY` (16).
- R2: Once the history is full, each accepted sample x gives the result (5·x + 4·h) / 9, where h is the result produced D accepted samples earlier. The quotient truncates toward zero: a sum of -5 gives 0, and a sum of -9 gives -1.
- R3: The first D samples accepted after reset or after a configuration write are emitted unchanged.
- R4: The history term h is the earlier output, not the earlier input. With D = 1, an impulse of 900 followed by zeros gives 900, 400, 177, 78, and so on.
- R5: A configuration write loads D from `cfg_delay`. The value 0 becomes 1, and any value above 4096 becomes 4096.
- R6: Every configuration write restarts the pass-through phase. During the strobe cycle `in_ready` is 0, so no sample is taken in that cycle.
- R7: When `out_ready` is 1 and no configuration write is active, `in_ready` is 1. The result of an accepted sample appears on the output in the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_sample` and `out_valid` hold, and no input is accepted.
- R9: Full-scale inputs (32767 and -32768) give exact results with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block will take the input sample this cycle |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_sample | output | 16 | Signed filtered sample |
| cfg_we | input | 1 | Strobe that loads a new delay length |
| cfg_delay | input | 16 | Requested delay length, clamped to 1..4096 |

## Verification
Most internal faults show up at the ports within D accepted samples of the stimulus that exposes them, because the mixed term feeds back into every later result. A pointer that wraps at the wrong place, or a fill count that stops at the wrong length, changes the first mixed result after the pass-through phase. A divider off by one shows up in the first sum whose truncation matters, for example a negative sum that is not a multiple of nine. A fault in the stall path shows up in the very next cycle, as a changed held output or as a sample lost from the compared sequence.

// File: rtl/recho_pkg.sv
package recho_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int ACC_W       = 20;
    localparam int RECIP_SHIFT = 20;
    localparam int RECIP       = 116509;   // ceil(2^20 / 9)
    localparam int PROD_W      = 40;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef struct packed {
        sample_t fresh;
        sample_t echo;
        logic    primed;
    } mix_in_t;

    // 5*x + 4*h, built from shifts and adds in ACC_W signed bits
    function automatic acc_t weigh(sample_t x, sample_t h);
        acc_t fx;
        acc_t fh;
        fx = acc_t'(x);
        fh = acc_t'(h);
        return (fx <<< 2) + fx + (fh <<< 2);
    endfunction

    // Exact division by nine with truncation toward zero
    function automatic sample_t div9(acc_t s);
        logic [ACC_W-1:0]  mag;
        logic [PROD_W-1:0] prod;
        logic [ACC_W-1:0]  q;
        logic [ACC_W-1:0]  back;
        sample_t           res;
        mag  = s[ACC_W-1] ? ACC_W'(-s) : ACC_W'(s);
        prod = PROD_W'(mag) * PROD_W'(RECIP);
        q    = ACC_W'(prod >> RECIP_SHIFT);
        back = (q << 3) + q;
        if (back > mag)
            q = q - ACC_W'(1);
        else if ((mag - back) >= ACC_W'(9))
            q = q + ACC_W'(1);
        res = sample_t'(q);
        return s[ACC_W-1] ? -res : res;
    endfunction

endpackage

// File: rtl/recho_delay_cfg.sv
module recho_delay_cfg
#(
    parameter int MAX_DELAY     = 4096,
    parameter int DEFAULT_DELAY = 16,
    parameter int CFG_W         = 16,
    localparam int LW           = $clog2(MAX_DELAY + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_delay,
    output logic [LW-1:0]    len
);

    logic [LW-1:0] clamped;

    always_comb begin
        if (cfg_delay == '0)
            clamped = LW'(1);
        else if (32'(cfg_delay) > MAX_DELAY)
            clamped = LW'(MAX_DELAY);
        else
            clamped = LW'(cfg_delay);
    end

    always_ff @(posedge clk) begin
        if (rst)
            len <= LW'(DEFAULT_DELAY);
        else if (cfg_we)
            len <= clamped;
    end

    p_len_range_r5: assert property (@(posedge clk) disable iff (rst)
        (len >= LW'(1)) && (32'(len) <= MAX_DELAY));

    p_write_loads_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_delay == '0) |=> (len == LW'(1)));

endmodule

// File: rtl/recho_delay_line.sv
module recho_delay_line
    import recho_pkg::*;
#(
    parameter int MAX_DELAY = 4096,
    localparam int AW       = $clog2(MAX_DELAY),
    localparam int LW       = $clog2(MAX_DELAY + 1)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [LW-1:0] len,
    input  logic          advance,
    input  sample_t       wr_data,
    output sample_t       rd_data,
    output logic          primed
);

    sample_t       mem [MAX_DELAY];
    logic [AW-1:0] ptr;
    logic [LW-1:0] fill;
    logic          at_end;

    // read-before-write: the slot read now is overwritten at this edge
    assign rd_data = mem[ptr];
    assign primed  = (fill == len);
    assign at_end  = (LW'(ptr) == (len - LW'(1)));

    always_ff @(posedge clk) begin
        if (advance)
            mem[ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ptr  <= '0;
            fill <= '0;
        end else if (advance) begin
            ptr <= at_end ? '0 : ptr + AW'(1);
            if (!primed)
                fill <= fill + LW'(1);
        end
    end

    p_ptr_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        LW'(ptr) < len);

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= len);

    p_restart_empties_r6: assert property (@(posedge clk) disable iff (rst)
        restart |=> !primed);

endmodule

// File: rtl/recho_mixer.sv
module recho_mixer
    import recho_pkg::*;
(
    input  mix_in_t req,
    output sample_t result
);

    always_comb begin
        if (req.primed)
            result = div9(weigh(req.fresh, req.echo));
        else
            result = req.fresh;
    end

endmodule

// File: rtl/recho_out_stage.sv
module recho_out_stage
    import recho_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sample_t din,
    input  logic    out_ready,
    output logic    out_valid,
    output sample_t out_data,
    output logic    free
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (load)
                out_valid <= 1'b1;
            else if (out_ready)
                out_valid <= 1'b0;
            if (load)
                out_data <= din;
        end
    end

    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/recho_filter.sv
module recho_filter
    import recho_pkg::*;
#(
    parameter int MAX_DELAY     = 4096,
    parameter int DEFAULT_DELAY = 16,
    parameter int CFG_W         = 16,
    localparam int LW           = $clog2(MAX_DELAY + 1)
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic signed [SAMPLE_W-1:0] out_sample,
    input  logic                       cfg_we,
    input  logic [CFG_W-1:0]           cfg_delay
);

    logic [LW-1:0] len;
    logic          free;
    logic          accept;
    logic          primed;
    sample_t       echo;
    sample_t       mixed;
    mix_in_t       req;

    assign in_ready = free && !cfg_we;
    assign accept   = in_valid && in_ready;

    assign req.fresh  = in_sample;
    assign req.echo   = echo;
    assign req.primed = primed;

    recho_delay_cfg #(
        .MAX_DELAY     (MAX_DELAY),
        .DEFAULT_DELAY (DEFAULT_DELAY),
        .CFG_W         (CFG_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_delay (cfg_delay),
        .len       (len)
    );

    recho_delay_line #(
        .MAX_DELAY (MAX_DELAY)
    ) u_line (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_we),
        .len     (len),
        .advance (accept),
        .wr_data (mixed),
        .rd_data (echo),
        .primed  (primed)
    );

    recho_mixer u_mix (
        .req    (req),
        .result (mixed)
    );

    recho_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .din       (mixed),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_sample),
        .free      (free)
    );

    p_cfg_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !in_ready);

    p_accept_emits_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    p_passthrough_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !primed) |=> (out_sample == $past(in_sample)));

    p_stall_no_take_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/recho_filter_tb.sv
module recho_filter_tb;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic               in_ready;
    logic signed [15:0] in_sample;
    logic               out_valid;
    logic               out_ready;
    logic signed [15:0] out_sample;
    logic               cfg_we;
    logic [15:0]        cfg_delay;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    exp_q[$];
    int    hist[$];
    int    m_d    = 16;
    int    m_fill = 0;
    string cur_tag = "R1";
    bit    stall_prev = 1'b0;
    int    stall_data = 0;

    always #4 clk = ~clk;   // 125 MHz

    recho_filter u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample),
        .cfg_we     (cfg_we),
        .cfg_delay  (cfg_delay)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ref_mix(int x, int h);
        return (5 * x + 4 * h) / 9;   // integer division truncates toward zero
    endfunction

    function automatic int clamp_d(int v);
        if (v == 0) return 1;
        if (v > 4096) return 4096;
        return v;
    endfunction

    task automatic cyc(bit v, int x, bit rdy, bit we, int dv);
        int y;
        @(negedge clk);
        in_valid  = v;
        in_sample = 16'(x);
        out_ready = rdy;
        cfg_we    = we;
        cfg_delay = 16'(dv);
        #1;
        if (stall_prev)
            check(out_valid && int'(out_sample) == stall_data, "R8",
                  int'(out_sample), stall_data);
        stall_prev = out_valid && !out_ready;
        stall_data = int'(out_sample);
        if (we) check(!in_ready, "R6", int'(in_ready), 0);
        if (!we && rdy) check(in_ready, "R7", int'(in_ready), 1);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) check(1'b0, cur_tag, int'(out_sample), -99999);
            else begin
                y = exp_q.pop_front();
                check(int'(out_sample) == y, cur_tag, int'(out_sample), y);
            end
        end
        if (in_valid && in_ready) begin
            if (m_fill < m_d) y = x;
            else y = ref_mix(x, hist[hist.size() - m_d]);
            exp_q.push_back(y);
            hist.push_back(y);
            if (hist.size() > 4096) void'(hist.pop_front());
            if (m_fill < m_d) m_fill++;
        end
        if (we) begin
            m_d = clamp_d(dv);
            m_fill = 0;
            hist.delete();
        end
    endtask

    function automatic int rnd_sample();
        return int'($signed(16'($urandom())));
    endfunction

    task automatic drain();
        for (int i = 0; i < 8; i++) cyc(1'b0, 0, 1'b1, 1'b0, 0);
        check(exp_q.size() == 0, cur_tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 0; in_sample = 0; out_ready = 0; cfg_we = 0; cfg_delay = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);

        // R3/R2: default delay 16, pass-through then mixing
        cur_tag = "R3";
        for (int i = 0; i < 40; i++) cyc(1'b1, (i * 811) - 9000, 1'b1, 1'b0, 0);
        drain();

        // R4: impulse response with D = 1
        cur_tag = "R4";
        cyc(1'b0, 0, 1'b1, 1'b1, 1);
        cyc(1'b1, 900, 1'b1, 1'b0, 0);
        for (int i = 0; i < 6; i++) cyc(1'b1, 0, 1'b1, 1'b0, 0);
        drain();

        // R5/R2: write 0 clamps to 1; negative truncation toward zero
        cur_tag = "R5";
        cyc(1'b0, 0, 1'b1, 1'b1, 0);
        cyc(1'b1, 0, 1'b1, 1'b0, 0);
        cur_tag = "R2";
        cyc(1'b1, -1, 1'b1, 1'b0, 0);   // (-5+0)/9 -> 0
        cyc(1'b1, -1, 1'b1, 1'b0, 0);   // (-5+0)/9 -> 0
        cyc(1'b1, -9, 1'b1, 1'b0, 0);   // -45/9 -> -5
        cyc(1'b1, -1, 1'b1, 1'b0, 0);   // (-5-20)/9 -> -2
        drain();

        // R9: full-scale alternation with D = 3
        cur_tag = "R9";
        cyc(1'b0, 0, 1'b1, 1'b1, 3);
        for (int i = 0; i < 30; i++)
            cyc(1'b1, (i % 3 == 2) ? -32768 : 32767, 1'b1, 1'b0, 0);
        cyc(1'b0, 0, 1'b1, 1'b1, 2);
        for (int i = 0; i < 30; i++) cyc(1'b1, -32768, 1'b1, 1'b0, 0);
        drain();

        // R8/R2: random valid and ready with D = 7
        cur_tag = "R8";
        cyc(1'b0, 0, 1'b1, 1'b1, 7);
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom()), rnd_sample(), ($urandom() % 4) != 0, 1'b0, 0);
        drain();

        // R5: large request clamps to 4096
        cur_tag = "R5";
        cyc(1'b0, 0, 1'b1, 1'b1, 5000);
        for (int i = 0; i < 4120; i++) cyc(1'b1, rnd_sample(), 1'b1, 1'b0, 0);
        drain();

        // R6: configuration writes mid-stream with random traffic
        cur_tag = "R6";
        for (int i = 0; i < 600; i++) begin
            if (i % 150 == 75)
                cyc(1'($urandom()), rnd_sample(), 1'($urandom()), 1'b1, 1 + ($urandom() % 40));
            else
                cyc(1'($urandom()), rnd_sample(), ($urandom() % 3) != 0, 1'b0, 0);
        end
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule